// File: doc/BRIEF.md
# Polynomial-Hashed MAC Address Lookup Engine

This block resolves a 48-bit station address to a record pointer held in external SRAM. On a start strobe it multiplies the address by a programmable 48-bit polynomial modulo a fixed irreducible degree-48 polynomial over GF(2). This mapping is one-to-one, so the 48-bit result stands for the address. The low 16 bits of the result pick one word of a 64K-word bucket table. The high 32 bits, called the remainder, are matched against the remainders stored in the records. The bucket holds no records. Each bucket word is empty, or it names a run of one to seven records sorted by remainder, and the engine probes that run in binary-search order. A remainder match alone is a hit.

A bucket may receive more than seven addresses. The extra addresses sit in a 32-entry associative overflow table with full 48-bit keys. The engine consults this table only when the bucket path has failed. A lookup makes at most four SRAM reads. The read port has a fixed latency. The engine reports the outcome with a one-cycle done pulse, a hit flag and the record pointer. Table contents, overflow entries and the multiplier value are supplied from outside.

The engine steps through eight named states. IDLE waits for a start. HASH runs the multiply. BKT_RD issues the bucket read. BKT_WT takes the bucket word: an empty bucket goes to OVF, and an occupied bucket goes to NODE_RD. NODE_RD issues a record read at the current midpoint. NODE_WT compares the remainder. On a match it goes to FIN. When it narrows to an empty range it goes to OVF. Otherwise it goes back to NODE_RD. OVF samples the overflow table and goes to FIN. FIN pulses done and returns to IDLE.

Top module: `lkp_hash_engine`

## Requirements
- R1: The hash is H = M(x)·A(x) mod (x^48 + x^36 + x^25 + x^10 + 1) over GF(2), with address bit i as the coefficient of x^i. H[15:0] is the bucket index, which is also the SRAM word address of the bucket. H[47:16] is the remainder.
- R2: The multiplier resets to 1. It is replaced by mult_in only when mult_load is high while busy is low and mult_in is nonzero. A load while busy, or a load of zero, is ignored. A new value applies to lookups started in later cycles.
- R3: A bucket word carries a count in bits [2:0] and a record base pointer in bits [31:3]. A count of 0 means empty: the lookup makes exactly one read and then goes to the overflow table.
- R4: With a count of 1, the single record at the base pointer is read. Its bits [31:0] equal to H[47:16] is a hit, and any other value is a bucket-path miss.
- R5: With a count n from 2 to 7, records base..base+n-1 hold remainders in ascending unsigned order. The engine keeps a range lo..hi, starting at 0..n-1. It reads the record at floor((lo+hi)/2). If the target is smaller, hi becomes mid-1; if larger, lo becomes mid+1. It stops on a match or when the range is empty. A lookup never makes more than four reads.
- R6: A bucket hit returns hit=1 and rec_ptr = base + index of the matching record. A total miss returns hit=0 and rec_ptr=0.
- R7: The overflow table has 32 entries, each with a valid flag, a 48-bit key and a pointer. It is written through the ovf_wr_* port. It is consulted only after a bucket-path miss, so a bucket hit wins. A matching valid entry gives hit=1 and that entry's pointer. When several entries match, the lowest index wins.
- R8: busy rises in the cycle after an accepted start and stays high until done. A start while busy is ignored.
- R9: done is high for exactly one cycle per lookup. hit and rec_ptr change only in the cycle that done is high, and hold their values otherwise.
- R10: Every read is a one-cycle mem_rd_en pulse with mem_rd_addr. The read data is sampled RD_LAT cycles later. No read is issued while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mult_load | input | 1 | Load strobe for the hash multiplier |
| mult_in | input | 48 | New multiplier value |
| start | input | 1 | Begin a lookup of addr |
| addr | input | 48 | Address to look up |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Result: address found |
| rec_ptr | output | 29 | Result: record pointer |
| mem_rd_en | output | 1 | SRAM read request |
| mem_rd_addr | output | 29 | SRAM word address |
| mem_rd_data | input | 32 | SRAM read data, RD_LAT cycles after request |
| ovf_wr_en | input | 1 | Overflow table write strobe |
| ovf_wr_idx | input | 5 | Overflow entry index |
| ovf_wr_valid | input | 1 | Valid flag written to the entry |
| ovf_wr_key | input | 48 | 48-bit key written to the entry |
| ovf_wr_ptr | input | 29 | Pointer written to the entry |

## Verification
Lookups run with the reset identity multiplier, where the bucket index and remainder are plain address slices. They also run with a random multiplier, where only a correct GF(2) reduction lands on the populated bucket. Random bucket runs of every count from 0 to 7 place the target at each sorted position, or leave it out at each insertion slot. The exact read count then separates the floor-midpoint probe order from any other order. Overflow entries are added to some bucket misses and to some bucket hits, which shows both the fallback and the precedence of the bucket path. Directed cases load the multiplier mid-lookup and load a zero multiplier, which separates ignored loads from accepted ones. A second start during a lookup shows whether an extra completion appears.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

    localparam int KEY_W = 48;
    localparam int IDX_W = 16;
    localparam int REM_W = KEY_W - IDX_W;
    localparam int CNT_W = 3;
    localparam logic [KEY_W-1:0] GEN_LOW = 48'h0010_0200_0401;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HASH,
        ST_BKT_RD,
        ST_BKT_WT,
        ST_NODE_RD,
        ST_NODE_WT,
        ST_OVF,
        ST_FIN
    } lkp_state_t;

    // one Horner step: acc*x mod G, plus m when the address bit is set
    function automatic logic [KEY_W-1:0] gf_step(input logic [KEY_W-1:0] acc,
                                                 input logic abit,
                                                 input logic [KEY_W-1:0] m);
        logic [KEY_W-1:0] sh;
        sh = {acc[KEY_W-2:0], 1'b0} ^ (acc[KEY_W-1] ? GEN_LOW : '0);
        return sh ^ (abit ? m : '0);
    endfunction

    function automatic logic [KEY_W-1:0] gf_mulmod(input logic [KEY_W-1:0] m,
                                                   input logic [KEY_W-1:0] a);
        logic [KEY_W-1:0] acc;
        acc = '0;
        for (int i = KEY_W - 1; i >= 0; i--) begin
            acc = gf_step(acc, a[i], m);
        end
        return acc;
    endfunction

endpackage

// File: rtl/lkp_gf_hash.sv
module lkp_gf_hash
    import lkp_pkg::*;
#(
    parameter bit SERIAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key,
    input  logic [KEY_W-1:0] mult,
    output logic [KEY_W-1:0] hash,
    output logic             vld
);

    localparam int CW = $clog2(KEY_W);

    generate
        if (SERIAL) begin : g_serial
            logic [KEY_W-1:0] acc_q;
            logic [KEY_W-1:0] sh_q;
            logic [CW-1:0]    cnt_q;
            logic             run_q;
            logic             vld_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc_q <= '0;
                    sh_q  <= '0;
                    cnt_q <= '0;
                    run_q <= 1'b0;
                    vld_q <= 1'b0;
                end else begin
                    vld_q <= 1'b0;
                    if (start) begin
                        acc_q <= '0;
                        sh_q  <= key;
                        cnt_q <= '0;
                        run_q <= 1'b1;
                    end else if (run_q) begin
                        acc_q <= gf_step(acc_q, sh_q[KEY_W-1], mult);
                        sh_q  <= {sh_q[KEY_W-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(KEY_W - 1)) begin
                            run_q <= 1'b0;
                            vld_q <= 1'b1;
                        end
                    end
                end
            end

            assign hash = acc_q;
            assign vld  = vld_q;
        end else begin : g_unrolled
            logic [KEY_W-1:0] hash_q;
            logic             vld_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hash_q <= '0;
                    vld_q  <= 1'b0;
                end else begin
                    vld_q <= start;
                    if (start) begin
                        hash_q <= gf_mulmod(mult, key);
                    end
                end
            end

            assign hash = hash_q;
            assign vld  = vld_q;
        end
    endgenerate

endmodule

// File: rtl/lkp_rd_port.sv
module lkp_rd_port #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    output logic rd_vld
);

    logic [LAT-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q[0] <= rd_en;
            for (int k = 1; k < LAT; k++) begin
                pend_q[k] <= pend_q[k-1];
            end
        end
    end

    assign rd_vld = pend_q[LAT-1];

endmodule

// File: rtl/lkp_ovf_cam.sv
module lkp_ovf_cam
    import lkp_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int PW    = 29,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [PW-1:0]    wr_ptr,
    input  logic [KEY_W-1:0] key,
    output logic             hit,
    output logic [PW-1:0]    ptr
);

    logic [DEPTH-1:0] vld_q;
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [PW-1:0]    ptr_q [DEPTH];
    logic [DEPTH-1:0] match;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[gi] <= 1'b0;
                    key_q[gi] <= '0;
                    ptr_q[gi] <= '0;
                end else if (wr_en && (wr_idx == IW'(gi))) begin
                    vld_q[gi] <= wr_valid;
                    key_q[gi] <= wr_key;
                    ptr_q[gi] <= wr_ptr;
                end
            end
            assign match[gi] = vld_q[gi] && (key_q[gi] == key);
        end
    endgenerate

    always_comb begin
        hit = |match;
        ptr = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                ptr = ptr_q[i];
            end
        end
    end

endmodule

// File: rtl/lkp_hash_engine.sv
module lkp_hash_engine
    import lkp_pkg::*;
#(
    parameter int RD_LAT      = 2,
    parameter int OVF_DEPTH   = 32,
    parameter bit SERIAL_HASH = 1'b1,
    localparam int DATA_W     = REM_W,
    localparam int AW         = DATA_W - CNT_W,
    localparam int OIW        = $clog2(OVF_DEPTH),
    localparam int RW         = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mult_load,
    input  logic [KEY_W-1:0]  mult_in,
    input  logic              start,
    input  logic [KEY_W-1:0]  addr,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [AW-1:0]     rec_ptr,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              ovf_wr_en,
    input  logic [OIW-1:0]    ovf_wr_idx,
    input  logic              ovf_wr_valid,
    input  logic [KEY_W-1:0]  ovf_wr_key,
    input  logic [AW-1:0]     ovf_wr_ptr
);

    lkp_state_t state_q, state_d;

    logic [KEY_W-1:0] mult_q;
    logic [KEY_W-1:0] key_q;
    logic [AW-1:0]    base_q;
    logic [RW-1:0]    lo_q;
    logic [RW-1:0]    end_q;
    logic             hit_q;
    logic [AW-1:0]    ptr_q;

    logic             accept;
    logic [KEY_W-1:0] hash;
    logic             hash_vld;
    logic             rd_vld;
    logic             cam_hit;
    logic [AW-1:0]    cam_ptr;

    logic [RW-1:0]    mid;
    logic [AW-1:0]    node_addr;
    logic [REM_W-1:0] target;
    logic [REM_W-1:0] node_rem;
    logic [CNT_W-1:0] bkt_cnt;
    logic [AW-1:0]    bkt_base;
    logic             rem_eq;
    logic             rem_lt;
    logic             range_out;

    assign accept    = start && (state_q == ST_IDLE);
    assign mid       = RW'((lo_q + end_q - RW'(1)) >> 1);
    assign node_addr = base_q + AW'(mid);
    assign target    = hash[KEY_W-1:IDX_W];
    assign node_rem  = mem_rd_data;
    assign bkt_cnt   = mem_rd_data[CNT_W-1:0];
    assign bkt_base  = mem_rd_data[DATA_W-1:CNT_W];
    assign rem_eq    = (node_rem == target);
    assign rem_lt    = (target < node_rem);
    assign range_out = rem_lt ? (lo_q >= mid) : ((mid + RW'(1)) >= end_q);

    lkp_gf_hash #(
        .SERIAL (SERIAL_HASH)
    ) u_hash (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .key   (addr),
        .mult  (mult_q),
        .hash  (hash),
        .vld   (hash_vld)
    );

    lkp_rd_port #(
        .LAT (RD_LAT)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (mem_rd_en),
        .rd_vld (rd_vld)
    );

    lkp_ovf_cam #(
        .DEPTH (OVF_DEPTH),
        .PW    (AW)
    ) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ovf_wr_en),
        .wr_idx   (ovf_wr_idx),
        .wr_valid (ovf_wr_valid),
        .wr_key   (ovf_wr_key),
        .wr_ptr   (ovf_wr_ptr),
        .key      (key_q),
        .hit      (cam_hit),
        .ptr      (cam_ptr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_HASH;
            ST_HASH:    if (hash_vld) state_d = ST_BKT_RD;
            ST_BKT_RD:  state_d = ST_BKT_WT;
            ST_BKT_WT:  if (rd_vld) state_d = (bkt_cnt == '0) ? ST_OVF : ST_NODE_RD;
            ST_NODE_RD: state_d = ST_NODE_WT;
            ST_NODE_WT: begin
                if (rd_vld) begin
                    if (rem_eq)         state_d = ST_FIN;
                    else if (range_out) state_d = ST_OVF;
                    else                state_d = ST_NODE_RD;
                end
            end
            ST_OVF:     state_d = ST_FIN;
            ST_FIN:     state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q <= KEY_W'(1);
            key_q  <= '0;
            base_q <= '0;
            lo_q   <= '0;
            end_q  <= '0;
            hit_q  <= 1'b0;
            ptr_q  <= '0;
        end else begin
            if ((state_q == ST_IDLE) && mult_load && (mult_in != '0)) begin
                mult_q <= mult_in;
            end
            if (accept) begin
                key_q <= addr;
            end
            if ((state_q == ST_BKT_WT) && rd_vld) begin
                base_q <= bkt_base;
                lo_q   <= '0;
                end_q  <= RW'(bkt_cnt);
            end
            if ((state_q == ST_NODE_WT) && rd_vld) begin
                if (rem_eq) begin
                    hit_q <= 1'b1;
                    ptr_q <= node_addr;
                end else if (rem_lt) begin
                    end_q <= mid;
                end else begin
                    lo_q <= mid + RW'(1);
                end
            end
            if (state_q == ST_OVF) begin
                hit_q <= cam_hit;
                ptr_q <= cam_hit ? cam_ptr : '0;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = 1'b1;
        done        = 1'b0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_BKT_RD: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = AW'(hash[IDX_W-1:0]);
            end
            ST_NODE_RD: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = node_addr;
            end
            ST_FIN:     done = 1'b1;
            default:    ;
        endcase
    end

    assign hit     = hit_q;
    assign rec_ptr = ptr_q;

endmodule

// File: rtl/lkp_hash_engine_chk.sv
module lkp_hash_engine_chk #(
    parameter int AW = 29
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          hit,
    input logic [AW-1:0] rec_ptr,
    input logic          mem_rd_en,
    input logic [47:0]   mult_q
);

    logic [3:0] rd_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt_q <= '0;
        end else if (start && !busy) begin
            rd_cnt_q <= '0;
        end else if (mem_rd_en && (rd_cnt_q != 4'hF)) begin
            rd_cnt_q <= rd_cnt_q + 4'd1;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hit) && $stable(rec_ptr)));

    // R10
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_en);

    // R5
    read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_cnt_q <= 4'd4));

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    mult_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mult_q));

endmodule

bind lkp_hash_engine lkp_hash_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .hit       (hit),
    .rec_ptr   (rec_ptr),
    .mem_rd_en (mem_rd_en),
    .mult_q    (mult_q)
);

// File: tb/lkp_hash_engine_tb.sv
module lkp_hash_engine_tb;

    localparam int RD_LAT = 2;
    localparam int AW     = 29;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mult_load = 1'b0;
    logic [47:0]   mult_in = '0;
    logic          start = 1'b0;
    logic [47:0]   addr = '0;
    logic          busy, done, hit;
    logic [AW-1:0] rec_ptr;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data;
    logic          ovf_wr_en = 1'b0;
    logic [4:0]    ovf_wr_idx = '0;
    logic          ovf_wr_valid = 1'b0;
    logic [47:0]   ovf_wr_key = '0;
    logic [AW-1:0] ovf_wr_ptr = '0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] mem [int unsigned];
    logic [31:0] pipe [RD_LAT];

    always #2 clk = ~clk;

    lkp_hash_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mult_load    (mult_load),
        .mult_in      (mult_in),
        .start        (start),
        .addr         (addr),
        .busy         (busy),
        .done         (done),
        .hit          (hit),
        .rec_ptr      (rec_ptr),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_data  (mem_rd_data),
        .ovf_wr_en    (ovf_wr_en),
        .ovf_wr_idx   (ovf_wr_idx),
        .ovf_wr_valid (ovf_wr_valid),
        .ovf_wr_key   (ovf_wr_key),
        .ovf_wr_ptr   (ovf_wr_ptr)
    );

    // fixed-latency SRAM model
    always @(posedge clk) begin
        pipe[0] <= (mem_rd_en && mem.exists(int'(mem_rd_addr))) ? mem[int'(mem_rd_addr)] : 32'h0;
        for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
    end
    assign mem_rd_data = pipe[RD_LAT-1];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // product then reduction, independent of the Horner form
    function automatic logic [47:0] ref_hash(input logic [47:0] m, input logic [47:0] a);
        logic [95:0] p;
        p = '0;
        for (int i = 0; i < 48; i++) if (a[i]) p ^= ({48'h0, m} << i);
        for (int i = 94; i >= 48; i--) if (p[i]) p ^= (96'h1_0010_0200_0401 << (i - 48));
        return p[47:0];
    endfunction

    function automatic logic [47:0] rnd48();
        return {16'($urandom()), 32'($urandom())};
    endfunction

    task automatic cam_write(input int idx, input bit v, input logic [47:0] k, input logic [AW-1:0] p);
        @(negedge clk);
        ovf_wr_en = 1'b1; ovf_wr_idx = 5'(idx); ovf_wr_valid = v; ovf_wr_key = k; ovf_wr_ptr = p;
        @(negedge clk);
        ovf_wr_en = 1'b0;
    endtask

    // mode: 0 plain, 1 second start mid-lookup, 2 multiplier load mid-lookup
    task automatic lookup(input logic [47:0] a, input int mode, input logic [47:0] xm,
                          output logic h, output logic [AW-1:0] p, output int nrd, output int ndone);
        logic hold_h;
        int cyc;
        @(negedge clk);
        start = 1'b1; addr = a;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
        cyc = 0; nrd = 0; ndone = 0;
        while (!done && cyc < 2000) begin
            if (mem_rd_en) nrd++;
            if (cyc == 5 && mode == 1) begin start = 1'b1; addr = ~a; end
            else if (cyc == 5 && mode == 2) begin mult_load = 1'b1; mult_in = xm; end
            else begin start = 1'b0; mult_load = 1'b0; end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; mult_load = 1'b0;
        chk(done === 1'b1, "R8", "lookup completes", 64'(done), 64'd1);
        h = hit; p = rec_ptr; hold_h = hit; ndone = 1;
        @(negedge clk);
        chk(done === 1'b0, "R9", "done lasts one cycle", 64'(done), 64'd0);
        chk(busy === 1'b0, "R8", "idle after done", 64'(busy), 64'd0);
        for (int k = 0; k < 60; k++) begin
            if (done) ndone++;
            @(negedge clk);
        end
        chk(hit === hold_h, "R9", "hit held", 64'(hit), 64'(hold_h));
    endtask

    // builds bucket + sorted run; returns expected bucket outcome and read count
    task automatic build(input logic [47:0] hsh, input int n, input bit hc, input int pos,
                         input logic [AW-1:0] base,
                         output bit found, output logic [AW-1:0] fptr, output int reads);
        logic [31:0] tv [8];
        logic [31:0] arr [8];
        logic [31:0] tg;
        int slots, lo, hi, md;
        tg = hsh[47:16];
        slots = hc ? n : n + 1;
        mem[int'({16'h0, hsh[15:0]})] = {base, 3'(n)};
        if (n > 0) begin
            tv[pos] = tg;
            for (int i = pos - 1; i >= 0; i--) tv[i] = tv[i+1] - 32'd1 - 32'($urandom() % 200);
            for (int i = pos + 1; i < slots; i++) tv[i] = tv[i-1] + 32'd1 + 32'($urandom() % 200);
            for (int i = 0; i < n; i++) arr[i] = (hc || i < pos) ? tv[i] : tv[i+1];
            for (int i = 0; i < n; i++) mem[int'(base) + i] = arr[i];
        end
        found = 1'b0; fptr = '0; reads = 1;
        lo = 0; hi = n - 1;
        while (!found && lo <= hi) begin
            md = (lo + hi) / 2;
            reads++;
            if (arr[md] == tg) begin found = 1'b1; fptr = base + AW'(md); end
            else if (tg < arr[md]) hi = md - 1;
            else lo = md + 1;
        end
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] a, m1, hs;
        logic h;
        logic [AW-1:0] p, fp, cp;
        int nrd, nd, n, pos, reads, cidx;
        bit hc, fnd, use_cam;
        string tag;

        void'($urandom(32'h1F2E3D4C));
        pipe[0] = '0; pipe[1] = '0;
        repeat (4) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R8", "reset busy/done", {62'h0, busy, done}, 64'h0);
        chk(hit === 1'b0 && rec_ptr === '0, "R6", "reset result", {34'h0, hit, rec_ptr}, 64'h0);
        rst_n = 1'b1;

        // R1 R2: reset multiplier is 1, so hash equals the address
        a = 48'hA1B2_C3D4_E5F6;
        mem.delete();
        mem[int'({16'h0, a[15:0]})] = {29'h0001_2340, 3'd1};
        mem[32'h0001_2340] = a[47:16];
        lookup(a, 0, '0, h, p, nrd, nd);
        chk(h === 1'b1, "R1", "identity hash hit", 64'(h), 64'd1);
        chk(p === 29'h0001_2340, "R4", "count-1 pointer", 64'(p), 64'h12340);
        chk(nrd == 2, "R4", "count-1 reads", 64'(nrd), 64'd2);

        // R2: random multiplier load
        m1 = rnd48() | 48'h1;
        @(negedge clk); mult_load = 1'b1; mult_in = m1;
        @(negedge clk); mult_load = 1'b0;

        for (int t = 0; t < 80; t++) begin
            do begin
                a = rnd48();
                hs = ref_hash(m1, a);
            end while (hs[47:16] < 32'd4096 || hs[47:16] > 32'hFFFF_F000);
            mem.delete();
            n = (t < 16) ? (t % 8) : int'($urandom() % 8);
            hc = (n > 0) && ($urandom() % 2 == 1);
            pos = hc ? int'($urandom() % n) : int'($urandom() % (n + 1));
            build(hs, n, hc, pos, 29'h0010_0000 + 29'(t * 8), fnd, fp, reads);
            use_cam = ($urandom() % 3 == 0);
            cidx = int'($urandom() % 32);
            cp = 29'(32'($urandom()));
            if (use_cam) cam_write(cidx, 1'b1, a, cp);
            lookup(a, 0, '0, h, p, nrd, nd);
            tag = (n == 0) ? "R3" : (n == 1) ? "R4" : "R5";
            if (fnd) begin
                chk(h === 1'b1 && p === fp, "R6", "bucket hit pointer", {34'h0, h, p}, {34'h0, 1'b1, fp});
            end else if (use_cam) begin
                chk(h === 1'b1 && p === cp, "R7", "overflow hit pointer", {34'h0, h, p}, {34'h0, 1'b1, cp});
            end else begin
                chk(h === 1'b0 && p === '0, "R6", "miss result", {34'h0, h, p}, 64'h0);
            end
            chk(nrd == reads, tag, "read count", 64'(nrd), 64'(reads));
            chk(nrd <= 4, "R5", "read budget", 64'(nrd), 64'd4);
            if (use_cam) cam_write(cidx, 1'b0, '0, '0);
        end

        // R5 R7: full bucket, target absent, held in overflow table
        a = 48'h0123_4567_89AB;
        hs = ref_hash(m1, a);
        mem.delete();
        build(hs, 7, 1'b0, 7, 29'h0020_0000, fnd, fp, reads);
        cam_write(9, 1'b1, a, 29'h0ABC_DEF0);
        cam_write(20, 1'b1, a, 29'h0000_0777);
        lookup(a, 0, '0, h, p, nrd, nd);
        chk(h === 1'b1 && p === 29'h0ABC_DEF0, "R7", "lowest overflow index wins", 64'(p), 64'h0ABCDEF0);
        chk(nrd == 4, "R5", "full bucket four reads", 64'(nrd), 64'd4);

        // R7: bucket hit beats an overflow entry for the same key
        mem.delete();
        build(hs, 3, 1'b1, 2, 29'h0030_0000, fnd, fp, reads);
        lookup(a, 0, '0, h, p, nrd, nd);
        chk(h === 1'b1 && p === 29'h0030_0002, "R7", "bucket path wins", 64'(p), 64'h300002);
        cam_write(9, 1'b0, '0, '0);
        cam_write(20, 1'b0, '0, '0);

        // R3: empty bucket, nothing in overflow
        mem.delete();
        lookup(a, 0, '0, h, p, nrd, nd);
        chk(h === 1'b0 && p === '0, "R3", "empty bucket miss", {34'h0, h, p}, 64'h0);
        chk(nrd == 1, "R3", "empty bucket reads", 64'(nrd), 64'd1);

        // R2: load while busy ignored, zero load ignored
        mem.delete();
        build(hs, 1, 1'b1, 0, 29'h0040_0000, fnd, fp, reads);
        lookup(a, 2, ~m1, h, p, nrd, nd);
        chk(h === 1'b1, "R2", "lookup with load mid-flight", 64'(h), 64'd1);
        lookup(a, 0, '0, h, p, nrd, nd);
        chk(h === 1'b1 && p === 29'h0040_0000, "R2", "busy load ignored", 64'(h), 64'd1);
        @(negedge clk); mult_load = 1'b1; mult_in = '0;
        @(negedge clk); mult_load = 1'b0;
        lookup(a, 0, '0, h, p, nrd, nd);
        chk(h === 1'b1, "R2", "zero load ignored", 64'(h), 64'd1);

        // R8: second start while busy produces no extra lookup
        lookup(a, 1, '0, h, p, nrd, nd);
        chk(nd == 1, "R8", "done pulses with start while busy", 64'(nd), 64'd1);
        chk(nrd == 2, "R10", "reads with start while busy", 64'(nrd), 64'd2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule